// File: doc/BRIEF.md
# Relocatable Window Address Decoder

This block sorts each bus transaction to one target. It has a set of relocatable address windows and one bridge forwarding range. Each window has a programmable base, an enable, a fixed power-of-two size and a fixed address space, either I/O or memory. A transaction claimed by a window or by the bridge range is decoded positively. A transaction that none of them claims goes to a subtractive target and does not end without a response. The block decodes only the address and the space type, and it registers the result one cycle after it accepts the request.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `dec_valid` is high and `dec_ready` is low, the result holds steady and no new request is taken. Window bases, enables, the bridge range and the mode bit of the storage controller are plain register-level inputs.

Top module: `addr_decoder`

## Requirements
- R1: A window of size 2^k claims an address when address bits [AW-1:k] equal base bits [AW-1:k]. The lower k bits of the address are ignored, so the first and last bytes of the aligned block both hit.
- R2: `req_space` is 0 for I/O and 1 for memory. A window claims only requests whose space matches its own type. With the default parameters, windows 0 to 5 are I/O and windows 6 and 7 are memory.
- R3: The windows in `NATIVE_MASK` (windows 0 to 3 by default) never claim a request while `native_mode` is 0.
- R4: A window whose enable bit in `win_en` is 0, or whose whole base is zero, claims nothing.
- R5: When more than one window matches, only the lowest-index window is reported in `dec_hit`.
- R6: With `bridge_en` high, a request whose address lies in [bridge_base, bridge_limit] (both ends inclusive, either space) and that no window claims sets `dec_bridge`. Windows take priority over the bridge range.
- R7: A request that neither a window nor the bridge range claims sets `dec_sub`.
- R8: While `dec_valid` is high, exactly one bit among `dec_hit`, `dec_bridge` and `dec_sub` is set.
- R9: `req_ready` equals `!dec_valid || dec_ready`. A request accepted on an edge sets `dec_valid` after that edge, and the result stays unchanged while `dec_valid` is high and `dec_ready` is low.
- R10: After reset, `dec_valid`, `dec_hit`, `dec_bridge` and `dec_sub` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The decoder can take a request |
| req_addr | input | AW | Address of the transaction |
| req_space | input | 1 | 0 = I/O, 1 = memory |
| win_base | input | NUM_WIN*AW | Base of each window, window i in bits [i*AW +: AW] |
| win_en | input | NUM_WIN | Enable for each window |
| native_mode | input | 1 | Storage controller native mode; gates the windows in NATIVE_MASK |
| bridge_en | input | 1 | Enables the bridge forwarding range |
| bridge_base | input | AW | Lowest address of the bridge range |
| bridge_limit | input | AW | Highest address of the bridge range |
| dec_valid | output | 1 | A decode result is held |
| dec_ready | input | 1 | The consumer takes the result |
| dec_hit | output | NUM_WIN | One-hot window hit |
| dec_bridge | output | 1 | The bridge range claimed the request |
| dec_sub | output | 1 | The request goes to the subtractive target |

## Verification
A fault in a match term or in the priority pick shows at the ports in the cycle after acceptance. It appears as a wrong bit in `dec_hit`, as two bits set at once, or as a claimed request that arrives at `dec_sub`. A fault in the output register or the handshake shows in the same cycle as a change in the held result during a stall, or as `req_ready` disagreeing with the output state. Each decode is independent of earlier ones, so no error hides across requests. The next decode exposes it.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic {
    SPACE_IO  = 1'b0,
    SPACE_MEM = 1'b1
  } space_e;
endpackage

// File: rtl/win_match.sv
module win_match
  import addr_dec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LOG2  = 2,
  parameter bit MEM   = 1'b0,
  parameter bit GATED = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          space,
  input  logic [AW-1:0] base,
  input  logic          en,
  input  logic          native,
  output logic          hit
);
  localparam logic [AW-1:0] MASK = ~((AW'(1) << LOG2) - AW'(1));
  localparam space_e WSPACE = MEM ? SPACE_MEM : SPACE_IO;

  logic same_block, live, allowed;

  always_comb begin
    same_block = ((addr ^ base) & MASK) == '0;
    live       = en && (base != '0);
    allowed    = GATED ? native : 1'b1;
    hit        = same_block && live && allowed && (space_e'(space) == WSPACE);
  end
endmodule

// File: rtl/range_match.sv
module range_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          en,
  output logic          hit
);
  always_comb hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] raw,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    pick = raw & (~raw + N'(1));
    any  = |raw;
  end
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder #(
  parameter int                    AW          = 32,
  parameter int                    NUM_WIN     = 8,
  parameter logic [NUM_WIN*4-1:0]  WIN_LOG2    = {4'd12, 4'd10, 4'd8, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2},
  parameter logic [NUM_WIN-1:0]    IS_MEM      = 8'b1100_0000,
  parameter logic [NUM_WIN-1:0]    NATIVE_MASK = 8'b0000_1111
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic                  req_space,
  input  logic [NUM_WIN*AW-1:0] win_base,
  input  logic [NUM_WIN-1:0]    win_en,
  input  logic                  native_mode,
  input  logic                  bridge_en,
  input  logic [AW-1:0]         bridge_base,
  input  logic [AW-1:0]         bridge_limit,
  output logic                  dec_valid,
  input  logic                  dec_ready,
  output logic [NUM_WIN-1:0]    dec_hit,
  output logic                  dec_bridge,
  output logic                  dec_sub
);
  logic [NUM_WIN-1:0] raw_hit, win_pick;
  logic               any_win, br_hit, take;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    win_match #(
      .AW   (AW),
      .LOG2 (int'(WIN_LOG2[i*4 +: 4])),
      .MEM  (IS_MEM[i]),
      .GATED(NATIVE_MASK[i])
    ) u_win (
      .addr  (req_addr),
      .space (req_space),
      .base  (win_base[i*AW +: AW]),
      .en    (win_en[i]),
      .native(native_mode),
      .hit   (raw_hit[i])
    );
  end

  range_match #(.AW(AW)) u_bridge (
    .addr(req_addr),
    .lo  (bridge_base),
    .hi  (bridge_limit),
    .en  (bridge_en),
    .hit (br_hit)
  );

  prio_pick #(.N(NUM_WIN)) u_pick (
    .raw (raw_hit),
    .pick(win_pick),
    .any (any_win)
  );

  always_comb begin
    req_ready = !dec_valid || dec_ready;
    take      = req_valid && req_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_hit    <= '0;
      dec_bridge <= 1'b0;
      dec_sub    <= 1'b0;
    end else if (take) begin
      dec_valid  <= 1'b1;
      dec_hit    <= win_pick;
      dec_bridge <= !any_win && br_hit;
      dec_sub    <= !any_win && !br_hit;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_decoder_chk.sv
module addr_decoder_chk #(
  parameter int                 NUM_WIN     = 8,
  parameter logic [NUM_WIN-1:0] IS_MEM      = '0,
  parameter logic [NUM_WIN-1:0] NATIVE_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_space,
  input logic [NUM_WIN-1:0] win_en,
  input logic               native_mode,
  input logic               bridge_en,
  input logic               dec_valid,
  input logic               dec_ready,
  input logic [NUM_WIN-1:0] dec_hit,
  input logic               dec_bridge,
  input logic               dec_sub
);
  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones({dec_hit, dec_bridge, dec_sub}) == 1);

  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> dec_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> dec_valid && $stable(dec_hit) && $stable(dec_bridge) && $stable(dec_sub));

  // R3
  native_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !native_mode) |=> (dec_hit & NATIVE_MASK) == '0);

  // R2
  io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_space) |=> (dec_hit & IS_MEM) == '0);

  // R2
  mem_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_space) |=> (dec_hit & ~IS_MEM) == '0);

  // R7
  nothing_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_en == '0 && !bridge_en) |=> dec_sub);
endmodule

bind addr_decoder addr_decoder_chk #(
  .NUM_WIN    (NUM_WIN),
  .IS_MEM     (IS_MEM),
  .NATIVE_MASK(NATIVE_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_space  (req_space),
  .win_en     (win_en),
  .native_mode(native_mode),
  .bridge_en  (bridge_en),
  .dec_valid  (dec_valid),
  .dec_ready  (dec_ready),
  .dec_hit    (dec_hit),
  .dec_bridge (dec_bridge),
  .dec_sub    (dec_sub)
);

// File: tb/test_addr_decoder.sv
module test_addr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_space = 1'b0;
  logic [NW*AW-1:0] win_base = '0;
  logic [NW-1:0] win_en = '0;
  logic native_mode = 1'b0;
  logic bridge_en = 1'b0;
  logic [AW-1:0] bridge_base = '0;
  logic [AW-1:0] bridge_limit = '0;
  logic dec_valid;
  logic dec_ready = 1'b1;
  logic [NW-1:0] dec_hit;
  logic dec_bridge;
  logic dec_sub;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_decoder i_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_space(req_space), .win_base(win_base),
    .win_en(win_en), .native_mode(native_mode), .bridge_en(bridge_en),
    .bridge_base(bridge_base), .bridge_limit(bridge_limit),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_hit(dec_hit),
    .dec_bridge(dec_bridge), .dec_sub(dec_sub)
  );

  task automatic expect_out(input string tag, input logic v, input logic [NW-1:0] h,
                            input logic b, input logic s);
    n_checks++;
    if (dec_valid !== v || dec_hit !== h || dec_bridge !== b || dec_sub !== s) begin
      n_fail++;
      $display("FAIL %s: got v=%b hit=%b br=%b sub=%b, expected v=%b hit=%b br=%b sub=%b",
               tag, dec_valid, dec_hit, dec_bridge, dec_sub, v, h, b, s);
    end
  endtask

  // One request, result checked in the cycle after acceptance.
  task automatic decode(input string tag, input logic [AW-1:0] a, input logic sp,
                        input logic [NW-1:0] h, input logic b, input logic s);
    @(negedge clk);
    req_addr = a; req_space = sp; req_valid = 1'b1; dec_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    expect_out(tag, 1'b1, h, b, s);
  endtask

  task automatic set_base(input int i, input logic [AW-1:0] b);
    win_base[i*AW +: AW] = b;
  endtask

  task automatic setup_map();
    set_base(0, 32'h0000_0100); // 4 B io, gated
    set_base(1, 32'h0000_0108); // 8 B io, gated
    set_base(2, 32'h0000_0110); // 16 B io, gated
    set_base(3, 32'h0000_0120); // 32 B io, gated
    set_base(4, 32'h0000_0140); // 64 B io
    set_base(5, 32'h0000_0100); // 256 B io, covers 0x100-0x1FF
    set_base(6, 32'hFED0_0000); // 1 KiB mem
    set_base(7, 32'hFED0_0000); // 4 KiB mem
    win_en = '1;
    native_mode = 1'b1;
    bridge_en = 1'b1;
    bridge_base = 32'h8000_0000;
    bridge_limit = 32'h8FFF_FFFF;
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_out("R10 reset", 1'b0, '0, 1'b0, 1'b0);
    n_checks++;
    if (req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 ready after reset: got %b expected 1", req_ready);
    end
  endtask

  task automatic t_windows();
    decode("R1 win0 first byte", 32'h100, 1'b0, 8'h01, 1'b0, 1'b0);
    decode("R1 win0 last byte", 32'h103, 1'b0, 8'h01, 1'b0, 1'b0);
    decode("R1 win1 last byte", 32'h10F, 1'b0, 8'h02, 1'b0, 1'b0);
    decode("R1 win3 middle", 32'h12C, 1'b0, 8'h08, 1'b0, 1'b0);
    decode("R1 win5 gap byte", 32'h104, 1'b0, 8'h20, 1'b0, 1'b0);
    decode("R1 win5 last byte", 32'h1FF, 1'b0, 8'h20, 1'b0, 1'b0);
    decode("R1 io past win5", 32'h200, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_priority();
    decode("R5 win4 over win5", 32'h140, 1'b0, 8'h10, 1'b0, 1'b0);
    decode("R5 win6 over win7", 32'hFED0_0010, 1'b1, 8'h40, 1'b0, 1'b0);
    decode("R5 win7 alone", 32'hFED0_0800, 1'b1, 8'h80, 1'b0, 1'b0);
    decode("R1 win7 last byte", 32'hFED0_0FFF, 1'b1, 8'h80, 1'b0, 1'b0);
  endtask

  task automatic t_space();
    decode("R2 io at mem window", 32'hFED0_0010, 1'b0, 8'h00, 1'b0, 1'b1);
    decode("R2 mem at io window", 32'h140, 1'b1, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_native();
    native_mode = 1'b0;
    decode("R3 gated win0 off", 32'h100, 1'b0, 8'h20, 1'b0, 1'b0);
    decode("R3 gated win3 off", 32'h12C, 1'b0, 8'h20, 1'b0, 1'b0);
    decode("R3 ungated win4 on", 32'h140, 1'b0, 8'h10, 1'b0, 1'b0);
    native_mode = 1'b1;
  endtask

  task automatic t_disable();
    win_en[0] = 1'b0;
    decode("R4 win0 enable low", 32'h100, 1'b0, 8'h20, 1'b0, 1'b0);
    win_en[0] = 1'b1;
    set_base(4, 32'h0);
    decode("R4 win4 base zero", 32'h140, 1'b0, 8'h20, 1'b0, 1'b0);
    decode("R4 base zero at addr 0", 32'h0, 1'b0, 8'h00, 1'b0, 1'b1);
    set_base(4, 32'h140);
  endtask

  task automatic t_bridge();
    decode("R6 bridge low end", 32'h8000_0000, 1'b1, 8'h00, 1'b1, 1'b0);
    decode("R6 bridge high end", 32'h8FFF_FFFF, 1'b1, 8'h00, 1'b1, 1'b0);
    decode("R6 bridge io space", 32'h8000_1000, 1'b0, 8'h00, 1'b1, 1'b0);
    decode("R7 above limit", 32'h9000_0000, 1'b1, 8'h00, 1'b0, 1'b1);
    decode("R7 below base", 32'h7FFF_FFFF, 1'b1, 8'h00, 1'b0, 1'b1);
    bridge_base = 32'h0000_0000; bridge_limit = 32'hFFFF_FFFF;
    decode("R6 window beats bridge", 32'h140, 1'b0, 8'h10, 1'b0, 1'b0);
    decode("R6 bridge takes rest", 32'h300, 1'b0, 8'h00, 1'b1, 1'b0);
    bridge_en = 1'b0;
    decode("R7 bridge disabled", 32'h300, 1'b0, 8'h00, 1'b0, 1'b1);
    bridge_en = 1'b1;
    bridge_base = 32'h8000_0000; bridge_limit = 32'h8FFF_FFFF;
  endtask

  task automatic t_stall();
    @(negedge clk);
    req_addr = 32'h140; req_space = 1'b0; req_valid = 1'b1; dec_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'hFED0_0800; req_space = 1'b1;
    expect_out("R9 first result", 1'b1, 8'h10, 1'b0, 1'b0);
    n_checks++;
    if (req_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 ready during stall: got %b expected 0", req_ready);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_out("R9 held during stall", 1'b1, 8'h10, 1'b0, 1'b0);
    end
    dec_ready = 1'b1;
    n_checks++;
    #1;
    if (req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 ready on drain: got %b expected 1", req_ready);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    expect_out("R9 second result", 1'b1, 8'h80, 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R9 drained", 1'b0, 8'h80, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    setup_map();
    t_windows();
    t_priority();
    t_space();
    t_native();
    t_disable();
    t_bridge();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule